// File: doc/BRIEF.md
# Management Link-Status Poller

This block watches the link state of an external Ethernet PHY when the device is set to face a PHY. It generates the management clock and issues a read frame over a two-wire management bus at a fixed interval. Each read fetches the PHY's basic status word, and the block takes the link state from that word. An active-low indicator output shows the result. In any other role the block stays quiet. It parks the management clock low, releases the data line and reports the link as down.

The PHY address is not programmed freely. Its upper three bits come from a configuration field, and its lower two bits come from the two strap pins that also set the device's own serial-bus address. The block samples this address at the start of each frame. The management clock divider, the poll interval, the register read and the status bit used for the link are all parameters.

Top module: `mgmt_link_poller`

## Requirements
- R1: During reset `mdc` is low, `mdio_oe` is low and `link_led_n` is high.
- R2: While `phy_role` is low, `mdc` stays low, `mdio_oe` stays low and `link_led_n` is high from the next clock on. Dropping `phy_role` during a frame abandons that frame.
- R3: Each read frame, counted in MDC bits, drives in order: 32 ones, start code 0 then 1, read opcode 1 then 0, the 5-bit PHY address MSB first, and the register address (default 1, bits 00001) MSB first. That is 46 driven bits.
- R4: The PHY address is `{addr_field[2:0], addr_strap[1:0]}`, with the field as the upper bits. It is captured when the frame starts.
- R5: The MDC period is 2*MDC_HALF system clocks, and MDC idles low. `mdio_o` changes only on a falling MDC edge, at the start of a frame, or when a frame is abandoned.
- R6: For frame bits 46 to 63 (two turnaround bits, then 16 data bits), `mdio_oe` is low. Data bits are sampled on rising MDC edges, MSB first.
- R7: `link_led_n` becomes the inverse of bit LINK_BIT (default 2) of the returned word. It updates on the falling MDC edge that ends bit 63 and holds until the next frame completes.
- R8: A new frame (`mdio_oe` rising) begins exactly POLL_GAP system clocks after the last falling MDC edge of the previous frame.
- R9: Status-word bits other than LINK_BIT have no effect on `link_led_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_role | input | 1 | High when the device faces an Ethernet PHY; enables polling |
| addr_field | input | 3 | Upper three PHY address bits from configuration |
| addr_strap | input | 2 | Lower two PHY address bits from the serial-address straps |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable (high = drive) |
| mdio_i | input | 1 | Management data in |
| link_led_n | output | 1 | Link indicator, low when link is up |

## Verification
Assertions check the following on every clock: the quiet state outside the PHY-facing role, that the data line changes only on MDC falls, that the line is released through turnaround and data, that the indicator moves only at a frame end or on leaving the role, and that no frame starts before the interval timer expires. Only the bench scenarios can show the content of each frame and the correct address concatenation. The same holds for the exact MDC period and the exact gap between frames. They also show the decoded link bit against status words whose other bits are set, and recovery after a frame is abandoned part way through.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

   localparam int PRE_BITS   = 32;
   localparam int PHY_AW     = 5;
   localparam int REG_AW     = 5;
   localparam int HDR_BITS   = PRE_BITS + 2 + 2 + PHY_AW + REG_AW;
   localparam int TA_BITS    = 2;
   localparam int DATA_BITS  = 16;
   localparam int FRAME_BITS = HDR_BITS + TA_BITS + DATA_BITS;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } poll_state_e;

   function automatic logic [HDR_BITS-1:0] build_header(
      input logic [PHY_AW-1:0] phy,
      input logic [REG_AW-1:0] regad);
      return {{PRE_BITS{1'b1}}, SOF_CODE, OP_READ, phy, regad};
   endfunction

endpackage

// File: rtl/mlp_mdc_div.sv
module mlp_mdc_div #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);

   logic tick;

   generate
      if (HALF < 1) begin : g_bad_half
         $error("mlp_mdc_div: HALF must be at least 1");
      end

      if (HALF == 1) begin : g_fast
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;

         assign tick = en && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!en || tick) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc <= 1'b0;
      end else if (!en) begin
         mdc <= 1'b0;
      end else if (tick) begin
         mdc <= ~mdc;
      end
   end

   assign rise_stb = tick & ~mdc;
   assign fall_stb = tick &  mdc;

   AST_MDC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !mdc); // R5

endmodule

// File: rtl/mlp_gap_timer.sv
module mlp_gap_timer #(
   parameter int GAP = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic en,
   output logic expired
);

   localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
   localparam logic [GW-1:0] LAST = GW'(GAP - 1);

   generate
      if (GAP < 2) begin : g_bad_gap
         $error("mlp_gap_timer: GAP must be at least 2");
      end
   endgenerate

   logic [GW-1:0] cnt_q;

   assign expired = en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (en && !expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/mlp_read_seq.sv
module mlp_read_seq
   import mlp_pkg::*;
#(
   parameter int REG_ADDR = 1,
   parameter int LINK_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              role,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic              gap_expired,
   input  logic              rise_stb,
   input  logic              fall_stb,
   output logic              run,
   output logic              gap_clear,
   output logic              gap_en,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i,
   output logic              link_up,
   output logic              frame_done
);

   localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] DATA_FIRST = IDX_W'(HDR_BITS + TA_BITS);
   localparam logic [IDX_W-1:0] HDR_END    = IDX_W'(HDR_BITS);

   generate
      if (LINK_BIT < 0 || LINK_BIT >= DATA_BITS) begin : g_bad_link
         $error("mlp_read_seq: LINK_BIT outside the status word");
      end
      if (REG_ADDR < 0 || REG_ADDR >= (1 << REG_AW)) begin : g_bad_reg
         $error("mlp_read_seq: REG_ADDR does not fit the register field");
      end
   endgenerate

   poll_state_e          state_q;
   logic [IDX_W-1:0]     idx_q;
   logic [IDX_W-1:0]     idx_nxt;
   logic [HDR_BITS-1:0]  hdr_q;
   logic [HDR_BITS-1:0]  hdr_new;
   logic [LINK_BIT:0]    sh_q;
   logic [LINK_BIT:0]    sh_next;

   // Only the last LINK_BIT+1 received bits are kept; bit LINK_BIT of the
   // word is then at the top once all 16 bits have arrived.
   generate
      if (LINK_BIT == 0) begin : g_sh1
         assign sh_next = mdio_i;
      end else begin : g_shn
         assign sh_next = {sh_q[LINK_BIT-1:0], mdio_i};
      end
   endgenerate

   assign hdr_new    = build_header(phy_addr, REG_AW'(REG_ADDR));
   assign idx_nxt    = idx_q + 1'b1;
   assign run        = (state_q == ST_RUN);
   assign gap_en     = (state_q == ST_WAIT);
   assign frame_done = run && role && fall_stb && (idx_q == LAST_IDX);
   assign gap_clear  = ((state_q == ST_IDLE) && role) || frame_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         hdr_q   <= '0;
         sh_q    <= '0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
         link_up <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               mdio_o  <= 1'b0;
               mdio_oe <= 1'b0;
               link_up <= 1'b0;
               if (role) begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (!role) begin
                  state_q <= ST_IDLE;
                  link_up <= 1'b0;
               end else if (gap_expired) begin
                  state_q <= ST_RUN;
                  idx_q   <= '0;
                  hdr_q   <= hdr_new;
                  mdio_o  <= hdr_new[HDR_BITS-1];
                  mdio_oe <= 1'b1;
               end
            end
            ST_RUN: begin
               if (!role) begin
                  state_q <= ST_IDLE;
                  mdio_o  <= 1'b0;
                  mdio_oe <= 1'b0;
                  link_up <= 1'b0;
               end else begin
                  if (rise_stb && (idx_q >= DATA_FIRST)) begin
                     sh_q <= sh_next;
                  end
                  if (fall_stb) begin
                     if (idx_q == LAST_IDX) begin
                        state_q <= ST_WAIT;
                        link_up <= sh_q[LINK_BIT];
                     end else begin
                        idx_q <= idx_nxt;
                        hdr_q <= hdr_q << 1;
                        if (idx_nxt < HDR_END) begin
                           mdio_o  <= hdr_q[HDR_BITS-2];
                           mdio_oe <= 1'b1;
                        end else begin
                           mdio_o  <= 1'b0;
                           mdio_oe <= 1'b0;
                        end
                     end
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (run && idx_q >= HDR_END) |-> !mdio_oe); // R6

   AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_o != $past(mdio_o)) |->
         ($past(fall_stb) || $rose(mdio_oe) || $fell(mdio_oe))); // R5

endmodule

// File: rtl/mgmt_link_poller.sv
module mgmt_link_poller
   import mlp_pkg::*;
#(
   parameter int MDC_HALF   = 2,
   parameter int POLL_GAP   = 64,
   parameter int REG_ADDR   = 1,
   parameter int LINK_BIT   = 2,
   parameter int FIELD_W    = 3,
   parameter int STRAP_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               phy_role,
   input  logic [FIELD_W-1:0] addr_field,
   input  logic [STRAP_W-1:0] addr_strap,
   output logic               mdc,
   output logic               mdio_o,
   output logic               mdio_oe,
   input  logic               mdio_i,
   output logic               link_led_n
);

   generate
      if (FIELD_W + STRAP_W != PHY_AW) begin : g_bad_addr
         $error("mgmt_link_poller: address parts must total the PHY address width");
      end
   endgenerate

   logic [PHY_AW-1:0] phy_addr;
   logic run, gap_clear, gap_en, gap_expired;
   logic rise_stb, fall_stb, link_up, frame_done;
   logic div_en;

   assign phy_addr = {addr_field, addr_strap};
   assign div_en   = run & phy_role;

   mlp_mdc_div #(.HALF(MDC_HALF)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (div_en),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mlp_gap_timer #(.GAP(POLL_GAP)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (gap_clear),
      .en      (gap_en),
      .expired (gap_expired)
   );

   mlp_read_seq #(.REG_ADDR(REG_ADDR), .LINK_BIT(LINK_BIT)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .role        (phy_role),
      .phy_addr    (phy_addr),
      .gap_expired (gap_expired),
      .rise_stb    (rise_stb),
      .fall_stb    (fall_stb),
      .run         (run),
      .gap_clear   (gap_clear),
      .gap_en      (gap_en),
      .mdio_o      (mdio_o),
      .mdio_oe     (mdio_oe),
      .mdio_i      (mdio_i),
      .link_up     (link_up),
      .frame_done  (frame_done)
   );

   assign link_led_n = ~link_up;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !phy_role |=> (!mdc && !mdio_oe && link_led_n)); // R2

   AST_LED_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(link_led_n) |-> ($past(frame_done) || !$past(phy_role))); // R7

   AST_START_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> $past(gap_expired)); // R8

endmodule

// File: tb/tb_mgmt_link_poller.sv
`timescale 1ns/1ps
module tb_mgmt_link_poller;

   localparam int HALF = 2;
   localparam int GAP  = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       phy_role = 1'b0;
   logic [2:0] addr_field = '0;
   logic [1:0] addr_strap = '0;
   logic       mdio_i = 1'b1;
   logic       mdc, mdio_o, mdio_oe, link_led_n;

   int vectors = 0;
   int miscompares = 0;
   int frames_done = 0;
   logic abort_flag = 1'b0;

   typedef struct packed {
      logic [4:0]  addr;
      logic [15:0] word;
   } item_t;
   item_t exp_q[$];

   always #5 clk = ~clk;

   mgmt_link_poller #(.MDC_HALF(HALF), .POLL_GAP(GAP)) dut (
      .clk(clk), .rst_n(rst_n), .phy_role(phy_role),
      .addr_field(addr_field), .addr_strap(addr_strap),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
      .link_led_n(link_led_n));

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   // Monitor and PHY model: pops expected items and compares each frame
   initial begin : monitor
      time t_end, t_start, t_r0, t_r1;
      bit prev_valid;
      bit have_led;
      logic last_led;
      prev_valid = 0; have_led = 0; last_led = 1'b1;
      t_end = 0; t_r0 = 0; t_r1 = 0;
      forever begin
         item_t it;
         logic [45:0] hdr;
         bit hdr_ok, oe_ok, aborted;
         @(posedge mdio_oe);
         t_start = $time;
         if (prev_valid)
            check((t_start - t_end) == GAP * 10, "R8", "poll gap in clocks",
                  (t_start - t_end) / 10, GAP);
         if (have_led)
            check(link_led_n == last_led, "R7", "indicator held between frames",
                  link_led_n, last_led);
         if (exp_q.size() == 0) begin
            check(0, "R3", "frame with no expected item", 1, 0);
            it = '0;
         end else begin
            it = exp_q.pop_front();
         end
         hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, it.addr, 5'd1};
         hdr_ok = 1; oe_ok = 1; aborted = 0;
         for (int k = 0; k < 64; k++) begin
            @(posedge mdc or posedge abort_flag);
            if (abort_flag) begin
               aborted = 1;
               break;
            end
            if (k == 0) t_r0 = $time;
            if (k == 1) t_r1 = $time;
            #1;
            if (k < 46) begin
               if (mdio_oe !== 1'b1 || mdio_o !== hdr[45-k]) hdr_ok = 0;
            end else if (mdio_oe !== 1'b0) begin
               oe_ok = 0;
            end
            if (k + 1 >= 48 && k + 1 <= 63) mdio_i = it.word[62-k];
            else mdio_i = 1'b1;
         end
         if (aborted) begin
            prev_valid = 0;
            have_led = 0;
            mdio_i = 1'b1;
         end else begin
            check(hdr_ok, "R3 R4", "header bits and PHY address", hdr_ok, 1);
            check(oe_ok, "R6", "bus released in turnaround and data", oe_ok, 1);
            check((t_r1 - t_r0) == 2 * HALF * 10, "R5", "mdc period in ns",
                  t_r1 - t_r0, 2 * HALF * 10);
            @(negedge mdc);
            t_end = $time;
            repeat (2) @(negedge clk);
            check(link_led_n == ~it.word[2], "R7 R9", "indicator after frame",
                  link_led_n, ~it.word[2]);
            last_led = ~it.word[2];
            have_led = 1;
            prev_valid = 1;
            frames_done++;
         end
      end
   end

   task automatic run_frame(input logic [2:0] f, input logic [1:0] s,
                            input logic [15:0] w);
      int target;
      @(negedge clk);
      addr_field = f;
      addr_strap = s;
      exp_q.push_back({f, s, w});
      phy_role = 1'b1;
      target = frames_done + 1;
      wait (frames_done >= target);
   endtask

   // Driver
   initial begin : driver
      bit quiet_ok;
      repeat (3) @(negedge clk);
      check(mdc == 1'b0 && mdio_oe == 1'b0 && link_led_n == 1'b1, "R1",
            "reset state", {mdc, mdio_oe, link_led_n}, 3'b001);
      rst_n = 1'b1;
      quiet_ok = 1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (mdc !== 1'b0 || mdio_oe !== 1'b0 || link_led_n !== 1'b1) quiet_ok = 0;
      end
      check(quiet_ok, "R2", "quiet while not facing a PHY", quiet_ok, 1);

      run_frame(3'd0, 2'd0, 16'h0004);
      run_frame(3'd5, 2'd3, 16'h7809);
      run_frame(3'd7, 2'd1, 16'hFFFF);
      run_frame(3'd2, 2'd2, 16'hFFFB);
      run_frame(3'd3, 2'd0, 16'h0024);

      // Abandon a frame part way through the header
      @(negedge clk);
      exp_q.push_back({3'd1, 2'd1, 16'h0000});
      @(posedge mdio_oe);
      repeat (100) @(negedge clk);
      phy_role = 1'b0;
      abort_flag = 1'b1;
      repeat (2) @(negedge clk);
      quiet_ok = 1;
      for (int i = 0; i < 40; i++) begin
         if (mdc !== 1'b0 || mdio_oe !== 1'b0 || link_led_n !== 1'b1) quiet_ok = 0;
         @(negedge clk);
      end
      check(quiet_ok, "R2", "frame abandoned when role drops", quiet_ok, 1);
      abort_flag = 1'b0;
      mdio_i = 1'b1;

      run_frame(3'd6, 2'd2, 16'h796D);
      run_frame(3'd4, 2'd3, 16'h0000);
      run_frame(3'd1, 2'd0, 16'h0004);

      summary();
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d frames", frames_done, 8);
      summary();
      $finish;
   end

endmodule